// File: doc/BRIEF.md
# Handshaking Parallel Data/Command Port

This block links a local processor to one external device over a 32-bit parallel word path and three control lines: a transmit strobe, a receive acknowledge and a flag that marks each word as data or as a command. Either end may act as sender. A direction bit chooses the local role. The block drives the word path, the flag and the strobe only as sender. As receiver it drives only the acknowledge line. Every pin is brought out as separate input, output and output-enable signals, so the pad ring can build the tri-state buffers.

Each word moves with a four-phase exchange. The sender places the word and flag on the pins, then raises the strobe. The receiver captures the word and raises the acknowledge. The sender then lowers the strobe, and the receiver lowers the acknowledge. A received data word goes into a read-holding register with a valid flag. While that register is full, no further data word is acknowledged. A received command word bypasses the data path. Its low eight bits become a service number, and an interrupt flag is raised for the processor. The flag stays set until the processor clears it.

The local side offers words through a valid/ready handshake and takes received words with a one-cycle take pulse. The pins are assumed to be synchronous to `clk`; any synchronisation is done outside the block.

Top module: `pdc_port`

## Requirements
- R1: After reset the block is a receiver. Only the acknowledge line is enabled, and it is driven low. `tx_ready`, `rd_valid` and `irq` are 0.
- R2: In the sender role the word, flag and strobe outputs are enabled and the acknowledge output is not. In the receiver role only the acknowledge output is enabled.
- R3: As sender, an accepted word appears on `pin_data_out`, with its flag on `pin_dc_out` (1 = command, 0 = data), one cycle before the strobe rises. Word and flag stay stable for as long as the strobe is high.
- R4: As sender, the strobe falls in the cycle after the acknowledge input is seen high. `tx_ready` returns only after the acknowledge input is low again.
- R5: As receiver, when the strobe input is high with flag 0, the word is stored in `rd_word`, `rd_valid` is set and the acknowledge rises, all at the next clock edge.
- R6: While `rd_valid` is set, a data strobe is not acknowledged. It is acknowledged at the second edge after `rd_take` clears the holding register.
- R7: As receiver, a strobe with flag 1 is acknowledged even when the holding register is full. Bits 7:0 of the word go to `irq_svc` and `irq` is set. `rd_word` and `rd_valid` are left unchanged.
- R8: `irq` stays set until `irq_clear`. If a new command arrives in the same cycle as `irq_clear`, `irq` stays set.
- R9: As receiver, the acknowledge falls in the cycle after the strobe input falls. While it is high, no further word is captured.
- R10: A change of `cfg_transmit` takes effect only when the strobe and the acknowledge are both low and the sender is idle. Until then the role is held.
- R11: In the receiver role `tx_valid` is ignored: `tx_ready` stays 0 and nothing is driven on the word pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_transmit | input | 1 | Requested role: 1 sender, 0 receiver |
| role_tx | output | 1 | Role in effect |
| tx_valid | input | 1 | Local word offered |
| tx_is_cmd | input | 1 | Offered word is a command |
| tx_word | input | 32 | Offered word |
| tx_ready | output | 1 | Sender can accept a word |
| rd_valid | output | 1 | Read-holding register full |
| rd_word | output | 32 | Received data word |
| rd_take | input | 1 | Local side takes the held word |
| irq | output | 1 | Command interrupt pending |
| irq_svc | output | 8 | Service number of the last command |
| irq_clear | input | 1 | Clear the pending interrupt |
| pin_data_in | input | 32 | Word pins, sampled |
| pin_data_out | output | 32 | Word pins, driven value |
| pin_data_oe | output | 1 | Word pins output enable |
| pin_dc_in | input | 1 | Flag pin, sampled |
| pin_dc_out | output | 1 | Flag pin, driven value |
| pin_dc_oe | output | 1 | Flag pin output enable |
| pin_dtx_in | input | 1 | Strobe pin, sampled |
| pin_dtx_out | output | 1 | Strobe pin, driven value |
| pin_dtx_oe | output | 1 | Strobe pin output enable |
| pin_drx_in | input | 1 | Acknowledge pin, sampled |
| pin_drx_out | output | 1 | Acknowledge pin, driven value |
| pin_drx_oe | output | 1 | Acknowledge pin output enable |

## Verification
On every cycle the assertions check that word and flag hold steady under a raised strobe, that the strobe falls right after an acknowledge, and that a data strobe against a full holding register is never acknowledged. They also check that a pending interrupt survives until it is cleared, and that the role changes only on an idle link. The bench scenarios are needed for the rest: the exact values captured into `rd_word` and `irq_svc`, the command that overrides a clear in the same cycle, the release of back-pressure after a take, a role request held back by a transfer in flight, and `tx_valid` being ignored in the receiver role.

// File: rtl/pdc_pkg.sv
// Shared types for the handshaking data/command port.
// Assumes: the flag value 1 marks a command word on the link.
package pdc_pkg;
    localparam logic FLAG_CMD = 1'b1;

    typedef enum logic [1:0] {
        TX_IDLE    = 2'd0,
        TX_SETUP   = 2'd1,
        TX_STROBE  = 2'd2,
        TX_RELEASE = 2'd3
    } tx_state_t;

    typedef enum logic {
        RX_WAIT_STB = 1'b0,
        RX_WAIT_REL = 1'b1
    } rx_state_t;
endpackage

// File: rtl/pdc_tx.sv
// Sender half: takes one local word, drives it with its flag, and runs the
// strobe side of the four-phase exchange.
// Assumes: en is held steady for a whole transfer (the role logic ensures it).
module pdc_tx
    import pdc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tx_valid,
    input  logic              tx_is_cmd,
    input  logic [DATA_W-1:0] tx_word,
    output logic              tx_ready,
    input  logic              ack_in,
    output logic [DATA_W-1:0] word_out,
    output logic              flag_out,
    output logic              stb_out,
    output logic              idle
);
    tx_state_t         state_q;
    logic [DATA_W-1:0] word_q;
    logic              flag_q;
    logic              stb_q;

    // Sequence one transfer: capture, set up, strobe, wait for release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            word_q  <= '0;
            flag_q  <= 1'b0;
            stb_q   <= 1'b0;
        end else begin
            case (state_q)
                TX_IDLE: begin
                    if (en && tx_valid) begin
                        word_q  <= tx_word;
                        flag_q  <= tx_is_cmd;
                        state_q <= TX_SETUP;
                    end
                end
                TX_SETUP: begin
                    stb_q   <= 1'b1;
                    state_q <= TX_STROBE;
                end
                TX_STROBE: begin
                    if (ack_in) begin
                        stb_q   <= 1'b0;
                        state_q <= TX_RELEASE;
                    end
                end
                default: begin
                    if (!ack_in) begin
                        state_q <= TX_IDLE;
                    end
                end
            endcase
        end
    end

    // Present the local handshake and the pin values.
    always_comb begin
        tx_ready = en && (state_q == TX_IDLE);
        idle     = (state_q == TX_IDLE);
        word_out = word_q;
        flag_out = flag_q;
        stb_out  = stb_q;
    end

    AST_WORD_STABLE_UNDER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_q && $past(stb_q)) |-> ($stable(word_q) && $stable(flag_q))); // R3
    AST_STROBE_FALLS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_STROBE && ack_in) |=> !stb_q); // R4
    AST_READY_WAITS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_RELEASE && ack_in) |=> !tx_ready); // R4
endmodule

// File: rtl/pdc_rx.sv
// Receiver half: answers the strobe with the acknowledge, steers data words to
// the read-holding register and command words to the interrupt latch.
// Assumes: the word and flag pins are steady while the strobe input is high.
module pdc_rx
    import pdc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SVC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              stb_in,
    input  logic              flag_in,
    input  logic [DATA_W-1:0] word_in,
    output logic              ack_out,
    input  logic              rd_take,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_word,
    input  logic              irq_clear,
    output logic              irq,
    output logic [SVC_W-1:0]  irq_svc
);
    rx_state_t         state_q;
    logic              ack_q;
    logic              valid_q;
    logic [DATA_W-1:0] hold_q;
    logic              irq_q;
    logic [SVC_W-1:0]  svc_q;
    logic              accept;
    logic              load_data;
    logic              load_cmd;

    // Decide whether the current strobe is taken this cycle.
    always_comb begin
        accept    = en && (state_q == RX_WAIT_STB) && stb_in &&
                    ((flag_in == FLAG_CMD) || !valid_q);
        load_data = accept && (flag_in != FLAG_CMD);
        load_cmd  = accept && (flag_in == FLAG_CMD);
    end

    // Run the acknowledge side of the four-phase exchange.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_WAIT_STB;
            ack_q   <= 1'b0;
        end else if (accept) begin
            state_q <= RX_WAIT_REL;
            ack_q   <= 1'b1;
        end else if (state_q == RX_WAIT_REL && !stb_in) begin
            state_q <= RX_WAIT_STB;
            ack_q   <= 1'b0;
        end
    end

    // Hold the last received data word until the local side takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            hold_q  <= '0;
        end else if (load_data) begin
            valid_q <= 1'b1;
            hold_q  <= word_in;
        end else if (rd_take) begin
            valid_q <= 1'b0;
        end
    end

    // Latch the service number and keep the interrupt until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            svc_q <= '0;
        end else if (load_cmd) begin
            irq_q <= 1'b1;
            svc_q <= word_in[SVC_W-1:0];
        end else if (irq_clear) begin
            irq_q <= 1'b0;
        end
    end

    // Drive the outputs from the registers.
    always_comb begin
        ack_out  = ack_q;
        rd_valid = valid_q;
        rd_word  = hold_q;
        irq      = irq_q;
        irq_svc  = svc_q;
    end

    AST_NO_ACK_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_WAIT_STB && stb_in && !flag_in && valid_q) |=> !ack_q); // R6
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clear) |=> irq_q); // R8
    AST_CMD_KEEPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_cmd && !rd_take) |=> ($stable(hold_q) && $stable(valid_q))); // R7
    AST_ACK_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && !stb_in) |=> !ack_q); // R9
endmodule

// File: rtl/pdc_role.sv
// Role register: applies a requested direction only while the link is idle.
// Assumes: line_stb and line_ack reflect whichever end drives each line.
module pdc_role (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_transmit,
    input  logic tx_idle,
    input  logic line_stb,
    input  logic line_ack,
    output logic role_tx
);
    logic role_q;
    logic link_idle;

    // Both lines low and no transfer queued in the sender.
    always_comb begin
        link_idle = !line_stb && !line_ack && tx_idle;
    end

    // Take the requested role when the link is quiet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            role_q <= 1'b0;
        end else if (link_idle) begin
            role_q <= cfg_transmit;
        end
    end

    assign role_tx = role_q;

    AST_ROLE_CHANGES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (role_q != $past(role_q)) |-> $past(link_idle)); // R10
endmodule

// File: rtl/pdc_port.sv
// Top of the handshaking data/command port. Joins the role register, the
// sender and the receiver, and splits every pin into in/out/enable signals.
// Assumes: pin inputs are synchronous to clk.
module pdc_port #(
    parameter int DATA_W = 32,
    parameter int SVC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_transmit,
    output logic              role_tx,
    input  logic              tx_valid,
    input  logic              tx_is_cmd,
    input  logic [DATA_W-1:0] tx_word,
    output logic              tx_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_word,
    input  logic              rd_take,
    output logic              irq,
    output logic [SVC_W-1:0]  irq_svc,
    input  logic              irq_clear,
    input  logic [DATA_W-1:0] pin_data_in,
    output logic [DATA_W-1:0] pin_data_out,
    output logic              pin_data_oe,
    input  logic              pin_dc_in,
    output logic              pin_dc_out,
    output logic              pin_dc_oe,
    input  logic              pin_dtx_in,
    output logic              pin_dtx_out,
    output logic              pin_dtx_oe,
    input  logic              pin_drx_in,
    output logic              pin_drx_out,
    output logic              pin_drx_oe
);
    logic role_q;
    logic tx_idle;
    logic tx_stb;
    logic rx_ack;
    logic line_stb;
    logic line_ack;

    // Select the live value of each handshake line by who owns it.
    always_comb begin
        line_stb = role_q ? tx_stb : pin_dtx_in;
        line_ack = role_q ? pin_drx_in : rx_ack;
    end

    pdc_role u_role (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_transmit (cfg_transmit),
        .tx_idle      (tx_idle),
        .line_stb     (line_stb),
        .line_ack     (line_ack),
        .role_tx      (role_q)
    );

    pdc_tx #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (role_q),
        .tx_valid  (tx_valid),
        .tx_is_cmd (tx_is_cmd),
        .tx_word   (tx_word),
        .tx_ready  (tx_ready),
        .ack_in    (pin_drx_in),
        .word_out  (pin_data_out),
        .flag_out  (pin_dc_out),
        .stb_out   (tx_stb),
        .idle      (tx_idle)
    );

    pdc_rx #(.DATA_W(DATA_W), .SVC_W(SVC_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (!role_q),
        .stb_in    (pin_dtx_in),
        .flag_in   (pin_dc_in),
        .word_in   (pin_data_in),
        .ack_out   (rx_ack),
        .rd_take   (rd_take),
        .rd_valid  (rd_valid),
        .rd_word   (rd_word),
        .irq_clear (irq_clear),
        .irq       (irq),
        .irq_svc   (irq_svc)
    );

    // Pin ownership follows the role in effect.
    always_comb begin
        role_tx     = role_q;
        pin_data_oe = role_q;
        pin_dc_oe   = role_q;
        pin_dtx_oe  = role_q;
        pin_dtx_out = tx_stb;
        pin_drx_oe  = !role_q;
        pin_drx_out = rx_ack;
    end

    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_stb && rx_ack)); // R2
endmodule

// File: tb/pdc_port_test.sv
module pdc_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_transmit = 1'b0;
    logic tx_valid = 1'b0, tx_is_cmd = 1'b0;
    logic [DW-1:0] tx_word = '0;
    logic rd_take = 1'b0, irq_clear = 1'b0;
    logic [DW-1:0] r_data = '0;
    logic r_dc = 1'b0, r_dtx = 1'b0, r_drx = 1'b0;
    logic role_tx, tx_ready, rd_valid, irq;
    logic [DW-1:0] rd_word, pin_data_out;
    logic [7:0] irq_svc;
    logic pin_data_oe, pin_dc_out, pin_dc_oe, pin_dtx_out, pin_dtx_oe, pin_drx_out, pin_drx_oe;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdc_port uut (
        .clk(clk), .rst_n(rst_n), .cfg_transmit(cfg_transmit), .role_tx(role_tx),
        .tx_valid(tx_valid), .tx_is_cmd(tx_is_cmd), .tx_word(tx_word), .tx_ready(tx_ready),
        .rd_valid(rd_valid), .rd_word(rd_word), .rd_take(rd_take),
        .irq(irq), .irq_svc(irq_svc), .irq_clear(irq_clear),
        .pin_data_in(r_data), .pin_data_out(pin_data_out), .pin_data_oe(pin_data_oe),
        .pin_dc_in(r_dc), .pin_dc_out(pin_dc_out), .pin_dc_oe(pin_dc_oe),
        .pin_dtx_in(r_dtx), .pin_dtx_out(pin_dtx_out), .pin_dtx_oe(pin_dtx_oe),
        .pin_drx_in(r_drx), .pin_drx_out(pin_drx_out), .pin_drx_oe(pin_drx_oe)
    );

    function automatic logic [7:0] exp_svc(input logic [DW-1:0] w);
        return w[7:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic wait_ack(input logic val);
        for (int i = 0; i < 40 && pin_drx_out != val; i++) @(negedge clk);
    endtask

    // Remote end sends one word; local receiver should answer.
    task automatic remote_send(input logic [DW-1:0] w, input logic cmd);
        r_data = w; r_dc = cmd;
        @(negedge clk);
        r_dtx = 1'b1;
        @(negedge clk);
        wait_ack(1'b1);
        check(pin_drx_out == 1'b1, "R5 ack raised", pin_drx_out, 1);
        r_dtx = 1'b0;
        @(negedge clk);
        check(pin_drx_out == 1'b0, "R9 ack released", pin_drx_out, 0);
    endtask

    task automatic local_take();
        rd_take = 1'b1;
        @(negedge clk);
        rd_take = 1'b0;
    endtask

    // Local sender pushes one word; bench plays the remote receiver.
    task automatic local_send(input logic [DW-1:0] w, input logic cmd, input int delay);
        for (int i = 0; i < 40 && !tx_ready; i++) @(negedge clk);
        tx_valid = 1'b1; tx_word = w; tx_is_cmd = cmd;
        @(negedge clk);
        tx_valid = 1'b0;
        check(pin_dtx_out == 1'b0 && pin_data_out == w && pin_dc_out == cmd,
              "R3 setup before strobe", pin_data_out, w);
        @(negedge clk);
        check(pin_dtx_out == 1'b1, "R3 strobe raised", pin_dtx_out, 1);
        repeat (delay) @(negedge clk);
        check(pin_dtx_out == 1'b1 && pin_data_out == w && pin_dc_out == cmd,
              "R3 word stable under strobe", pin_data_out, w);
        r_drx = 1'b1;
        @(negedge clk);
        check(pin_dtx_out == 1'b0, "R4 strobe falls after ack", pin_dtx_out, 0);
        @(negedge clk);
        check(tx_ready == 1'b0, "R4 ready held while ack high", tx_ready, 0);
        r_drx = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] w1, w2;
        void'($urandom(32'h5eed_2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!role_tx && !tx_ready && !rd_valid && !irq, "R1 reset outputs",
              {role_tx, tx_ready, rd_valid, irq}, 0);
        check(pin_drx_oe && !pin_drx_out && !pin_data_oe && !pin_dtx_oe && !pin_dc_oe,
              "R1 R2 receiver pin enables", {pin_drx_oe, pin_data_oe, pin_dtx_oe, pin_dc_oe}, 4'b1000);

        // R11 tx_valid ignored as receiver
        tx_valid = 1'b1; tx_word = 32'hdead_beef;
        repeat (3) @(negedge clk);
        check(!tx_ready && !pin_data_oe && !pin_dtx_out, "R11 offer ignored as receiver",
              {tx_ready, pin_data_oe}, 0);
        tx_valid = 1'b0;

        // R5 directed data word
        w1 = 32'h1234_5678;
        remote_send(w1, 1'b0);
        check(rd_valid && rd_word == w1, "R5 data captured", rd_word, w1);

        // R6 back-pressure while full
        w2 = 32'hcafe_0001;
        r_data = w2; r_dc = 1'b0;
        @(negedge clk);
        r_dtx = 1'b1;
        repeat (5) @(negedge clk);
        check(pin_drx_out == 1'b0 && rd_word == w1, "R6 no ack while full", pin_drx_out, 0);

        // R7 command accepted while full, hold untouched
        r_dtx = 1'b0;
        @(negedge clk);
        remote_send(32'h0000_a5c3, 1'b1);
        check(irq && irq_svc == exp_svc(32'h0000_a5c3), "R7 service number", irq_svc, 8'hc3);
        check(rd_valid && rd_word == w1, "R7 hold unchanged by command", rd_word, w1);

        // R6 release after take
        r_data = w2; r_dc = 1'b0;
        r_dtx = 1'b1;
        local_take();
        check(pin_drx_out == 1'b0, "R6 not yet acked in take cycle", pin_drx_out, 0);
        @(negedge clk);
        check(pin_drx_out == 1'b1 && rd_word == w2, "R6 acked after take", rd_word, w2);

        // R9 no second capture while ack high
        local_take();
        repeat (3) @(negedge clk);
        check(!rd_valid && pin_drx_out, "R9 no recapture while ack high", rd_valid, 0);
        r_dtx = 1'b0;
        @(negedge clk);
        check(!pin_drx_out, "R9 ack drops", pin_drx_out, 0);

        // R8 irq held, then set wins over clear
        repeat (4) @(negedge clk);
        check(irq, "R8 irq held", irq, 1);
        r_data = 32'h0000_0077; r_dc = 1'b1;
        @(negedge clk);
        r_dtx = 1'b1; irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
        check(irq && irq_svc == 8'h77, "R8 set wins over clear", irq_svc, 8'h77);
        r_dtx = 1'b0;
        @(negedge clk);
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
        check(!irq, "R8 irq cleared", irq, 0);

        // Random receive traffic
        for (int i = 0; i < 40; i++) begin
            logic [DW-1:0] w;
            logic c;
            w = $urandom;
            c = ($urandom % 3) == 0;
            remote_send(w, c);
            if (c) begin
                check(irq && irq_svc == exp_svc(w), "R7 random command", irq_svc, exp_svc(w));
                irq_clear = 1'b1; @(negedge clk); irq_clear = 1'b0;
            end else begin
                check(rd_valid && rd_word == w, "R5 random data", rd_word, w);
                repeat ($urandom % 3) @(negedge clk);
                local_take();
            end
        end

        // R10 role request held during a transfer
        r_data = 32'h0f0f_0f0f; r_dc = 1'b0;
        r_dtx = 1'b1;
        @(negedge clk);
        cfg_transmit = 1'b1;
        repeat (4) @(negedge clk);
        check(!role_tx, "R10 role held while busy", role_tx, 0);
        local_take();
        r_dtx = 1'b0;
        for (int i = 0; i < 10 && !role_tx; i++) @(negedge clk);
        check(role_tx, "R10 role taken when idle", role_tx, 1);
        check(pin_data_oe && pin_dc_oe && pin_dtx_oe && !pin_drx_oe, "R2 sender pin enables",
              {pin_data_oe, pin_dc_oe, pin_dtx_oe, pin_drx_oe}, 4'b1110);

        // Sender: directed then random
        local_send(32'h8000_0001, 1'b0, 0);
        check(tx_ready, "R4 ready back after release", tx_ready, 1);
        local_send(32'h0000_00ff, 1'b1, 3);
        for (int i = 0; i < 30; i++) begin
            local_send($urandom, 1'($urandom % 2), int'($urandom % 5));
        end

        // R10 request back to receiver during a send
        for (int i = 0; i < 40 && !tx_ready; i++) @(negedge clk);
        tx_valid = 1'b1; tx_word = 32'h5555_aaaa; tx_is_cmd = 1'b0;
        @(negedge clk);
        tx_valid = 1'b0;
        cfg_transmit = 1'b0;
        repeat (4) @(negedge clk);
        check(role_tx && pin_dtx_out, "R10 sender role held mid transfer", role_tx, 1);
        r_drx = 1'b1;
        repeat (2) @(negedge clk);
        check(role_tx, "R10 held while ack high", role_tx, 1);
        r_drx = 1'b0;
        repeat (2) @(negedge clk);
        check(!role_tx && !tx_ready && !pin_data_oe, "R10 R11 back to receiver", role_tx, 0);

        finish_run();
    end
endmodule